// File: doc/BRIEF.md
# PHY Interrupt Event Hub

This block is the interrupt-management corner of an Ethernet PHY's register set. It samples the live link, speed and duplex levels and shows them in a read-only status word. It watches a set of event sources and latches one flag per source. It then combines the flags, gated by per-source enables and a global enable, into a single registered interrupt. The sources are link quality, energy detect, link state, speed, duplex, auto-negotiation done, a counter at half-full, and the time-sync engine. Level sources are turned into events by comparing each input with the value sampled on the cycle before. Pulse sources are latched as they arrive.

Software reaches three words over a simple register bus. The status word is read-only. The control word holds an output enable, an interrupt enable, a test bit and a remap select. The event word has seven enables in its low byte and seven latched flags in its high byte. Reading the event word clears the flags. The interrupt leaves through a shared pin. With the output enable set, the block drives the pin low to signal an interrupt. With the output enable clear, the block releases the pin and samples it as a power-down request.

Top module: `phy_event_irq`

## Requirements
- R1: After reset, all three words read as 0. The pin is released (`intr_pin_oe`=0), `intr_pin_o` is 1 and `pwr_down_o` is 0.
- R2: The status word carries full-duplex on bit 2, 10 Mb/s on bit 1 and link-up on bit 0, with bits 15:3 reading 0. Reading it never clears the link bit while the link stays up.
- R3: In the control word, bit 0 is output enable, bit 1 is interrupt enable, bit 2 is test interrupt and bit 3 is remap select. All four are read/write. Bits 15:4 read 0 and ignore writes.
- R4: The event flags occupy bits 14:8 of the event word. Each flag has its enable at bit (flag bit − 8). The slots are: 8 counter half-full pulse, 9 auto-negotiation-done rising edge, 10 any link change, 11 duplex change, 12 speed change, 13 any energy-detect change, 14 link-quality pulse.
- R5: A speed or duplex change sets its flag only when link is up both in the sampled value and in the current input. Changes while the link is down are ignored.
- R6: With remap select at 1, the time-sync pulse sets slot 11 and a speed or duplex change sets slot 12. With remap select at 0, the time-sync pulse has no effect.
- R7: An event raises the interrupt only when the interrupt enable is 1 and that slot's enable bit is 1. Flags latch regardless of the enables.
- R8: While the test bit is 1, the interrupt stays asserted whatever the flags are.
- R9: A read of the event word returns the flags held before that read and clears them. The interrupt drops on the next cycle. An event arriving in the same cycle as the read stays latched.
- R10: `intr_pin_oe` follows the output enable bit. `intr_pin_o` is low exactly while the interrupt is asserted.
- R11: `pwr_down_o` is 1 one cycle after `intr_pin_i` is sampled low while the output enable is 0. It is forced to 0 on the cycle after any cycle in which the output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| link_up_i | input | 1 | Live link level |
| speed10_i | input | 1 | Live speed level, 1 = 10 Mb/s |
| full_dup_i | input | 1 | Live duplex level, 1 = full |
| energy_i | input | 1 | Energy-detect level |
| an_done_i | input | 1 | Auto-negotiation complete level |
| cnt_half_i | input | 1 | Counter half-full pulse |
| lqm_evt_i | input | 1 | Link-quality event pulse |
| ts_evt_i | input | 1 | Time-sync interrupt pulse |
| intr_pin_i | input | 1 | Sampled value of the shared pin |
| intr_pin_o | output | 1 | Active-low interrupt drive value |
| intr_pin_oe | output | 1 | Drive enable of the shared pin |
| pwr_down_o | output | 1 | Power-down request from the pin |

## Verification
The interrupt register is computed from the next-state values of flags, enables and control bits. An input change, a pulse, a control write or an event-word read therefore shows on `intr_pin_o` after exactly one rising edge. Read data and `pwr_down_o` also arrive one edge after their cause. The status word needs one edge of sampling before it can be read. Every bench step drives on a falling edge, crosses one rising edge and compares on the following falling edge. A change of the output enable reaches `pwr_down_o` one step later, and the bench inserts an idle step before that check.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  // event slot positions inside the event word (decoded by software)
  localparam int SLOT_LO     = 8;
  localparam int SLOT_CNT    = 8;
  localparam int SLOT_AN     = 9;
  localparam int SLOT_LINK   = 10;
  localparam int SLOT_DUP    = 11;
  localparam int SLOT_SPD    = 12;
  localparam int SLOT_NRG    = 13;
  localparam int SLOT_LQM    = 14;
  localparam int N_SLOT      = SLOT_LQM - SLOT_LO + 1;
  localparam int CTL_W       = 4;
  localparam int STAT_W      = 3;

  typedef struct packed {
    logic remap;   // bit 3
    logic test;    // bit 2
    logic ien;     // bit 1
    logic oe;      // bit 0
  } ctl_t;
endpackage

// File: rtl/phy_stat_edge.sv
module phy_stat_edge (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           link_i,
  input  logic                           spd_i,
  input  logic                           dup_i,
  input  logic                           nrg_i,
  input  logic                           an_i,
  output logic [phy_irq_pkg::STAT_W-1:0] stat_q,
  output logic                           link_chg,
  output logic                           spd_chg,
  output logic                           dup_chg,
  output logic                           nrg_chg,
  output logic                           an_rise
);
  logic nrg_q, an_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      nrg_q  <= 1'b0;
      an_q   <= 1'b0;
    end else begin
      stat_q <= {dup_i, spd_i, link_i};
      nrg_q  <= nrg_i;
      an_q   <= an_i;
    end
  end

  // speed/duplex only meaningful while link held up across both samples
  logic link_steady;
  assign link_steady = link_i & stat_q[0];

  assign link_chg = link_i ^ stat_q[0];
  assign spd_chg  = link_steady & (spd_i ^ stat_q[1]);
  assign dup_chg  = link_steady & (dup_i ^ stat_q[2]);
  assign nrg_chg  = nrg_i ^ nrg_q;
  assign an_rise  = an_i & ~an_q;

  assert_link_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!link_i) |-> (!spd_chg && !dup_chg));
endmodule

// File: rtl/phy_evt_latch.sv
module phy_evt_latch #(
  parameter int N = phy_irq_pkg::N_SLOT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags_d,
  output logic [N-1:0] flags_q
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    // a new event wins over a clear in the same cycle
    assign flags_d[k] = (flags_q[k] & ~clr) | set[k];

    always_ff @(posedge clk) begin
      if (rst) flags_q[k] <= 1'b0;
      else     flags_q[k] <= flags_d[k];
    end

    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(flags_q[k]) |-> $past(set[k]));
  end
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs #(
  parameter int              ADDR_W    = 5,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h10,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 5'h11,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 5'h12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic [phy_irq_pkg::STAT_W-1:0] stat_q,
  input  logic [phy_irq_pkg::N_SLOT-1:0] flags_q,
  output phy_irq_pkg::ctl_t              ctl_d,
  output phy_irq_pkg::ctl_t              ctl_q,
  output logic [phy_irq_pkg::N_SLOT-1:0] en_d,
  output logic [phy_irq_pkg::N_SLOT-1:0] en_q,
  output logic                           evt_rd
);
  import phy_irq_pkg::*;

  logic hit_stat, hit_ctl, hit_evt;
  assign hit_stat = (reg_addr == STAT_ADDR);
  assign hit_ctl  = (reg_addr == CTL_ADDR);
  assign hit_evt  = (reg_addr == EVT_ADDR);
  assign evt_rd   = reg_rd & hit_evt;

  logic wdata_unused;
  assign wdata_unused = ^reg_wdata[DATA_W-1:N_SLOT];

  always_comb begin
    ctl_d = ctl_q;
    en_d  = en_q;
    if (reg_wr && hit_ctl) ctl_d = ctl_t'(reg_wdata[CTL_W-1:0]);
    if (reg_wr && hit_evt) en_d  = reg_wdata[N_SLOT-1:0];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_stat) begin
      rd_mux[STAT_W-1:0] = stat_q;
    end else if (hit_ctl) begin
      rd_mux[CTL_W-1:0] = ctl_q;
    end else if (hit_evt) begin
      rd_mux[SLOT_LO +: N_SLOT] = flags_q;
      rd_mux[N_SLOT-1:0]        = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      en_q      <= '0;
      reg_rdata <= '0;
    end else begin
      ctl_q <= ctl_d;
      en_q  <= en_d;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assert_ctl_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit_ctl) |=> (reg_rdata[DATA_W-1:CTL_W] == '0));

  assert_stat_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit_stat) |=> (reg_rdata[DATA_W-1:STAT_W] == '0));
endmodule

// File: rtl/phy_event_irq.sv
module phy_event_irq #(
  parameter int                ADDR_W    = 5,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h10,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 5'h11,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 5'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              link_up_i,
  input  logic              speed10_i,
  input  logic              full_dup_i,
  input  logic              energy_i,
  input  logic              an_done_i,
  input  logic              cnt_half_i,
  input  logic              lqm_evt_i,
  input  logic              ts_evt_i,
  input  logic              intr_pin_i,
  output logic              intr_pin_o,
  output logic              intr_pin_oe,
  output logic              pwr_down_o
);
  import phy_irq_pkg::*;

  logic [STAT_W-1:0] stat_q;
  logic link_chg, spd_chg, dup_chg, nrg_chg, an_rise;
  logic [N_SLOT-1:0] set, flags_d, flags_q, en_d, en_q;
  ctl_t ctl_d, ctl_q;
  logic evt_rd;

  phy_stat_edge u_stat (
    .clk(clk), .rst(rst),
    .link_i(link_up_i), .spd_i(speed10_i), .dup_i(full_dup_i),
    .nrg_i(energy_i), .an_i(an_done_i),
    .stat_q(stat_q),
    .link_chg(link_chg), .spd_chg(spd_chg), .dup_chg(dup_chg),
    .nrg_chg(nrg_chg), .an_rise(an_rise)
  );

  // slot routing; remap moves time-sync into the duplex slot
  always_comb begin
    set = '0;
    set[SLOT_CNT  - SLOT_LO] = cnt_half_i;
    set[SLOT_AN   - SLOT_LO] = an_rise;
    set[SLOT_LINK - SLOT_LO] = link_chg;
    set[SLOT_NRG  - SLOT_LO] = nrg_chg;
    set[SLOT_LQM  - SLOT_LO] = lqm_evt_i;
    if (ctl_q.remap) begin
      set[SLOT_DUP - SLOT_LO] = ts_evt_i;
      set[SLOT_SPD - SLOT_LO] = spd_chg | dup_chg;
    end else begin
      set[SLOT_DUP - SLOT_LO] = dup_chg;
      set[SLOT_SPD - SLOT_LO] = spd_chg;
    end
  end

  phy_evt_latch #(.N(N_SLOT)) u_latch (
    .clk(clk), .rst(rst), .set(set), .clr(evt_rd),
    .flags_d(flags_d), .flags_q(flags_q)
  );

  phy_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_ADDR(STAT_ADDR), .CTL_ADDR(CTL_ADDR), .EVT_ADDR(EVT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_q(stat_q), .flags_q(flags_q),
    .ctl_d(ctl_d), .ctl_q(ctl_q), .en_d(en_d), .en_q(en_q),
    .evt_rd(evt_rd)
  );

  logic irq_d, irq_q, pd_q;
  assign irq_d = ctl_d.test | (ctl_d.ien & (|(flags_d & en_d)));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      pd_q  <= ~ctl_q.oe & ~intr_pin_i;
    end
  end

  assign intr_pin_o  = ~irq_q;
  assign intr_pin_oe = ctl_q.oe;
  assign pwr_down_o  = pd_q;

  assert_test_holds_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_q.test |-> irq_q);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_rd && set == '0 && !ctl_d.test) |=> !irq_q);

  assert_pd_masked_R11: assert property (@(posedge clk) disable iff (rst)
    intr_pin_oe |=> !pwr_down_o);
endmodule

// File: tb/sim_phy_event_irq.sv
module sim_phy_event_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_STAT = 5'h10, A_CTL = 5'h11, A_EVT = 5'h12;

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 write, 2 read
    logic [4:0]  addr;
    logic [15:0] wd;
    logic [7:0]  inp;   // [0]link [1]spd10 [2]fdx [3]energy [4]an [5]cnt [6]lqm [7]ts
    logic [15:0] exp;   // checked on reads
    logic        pin;   // expected intr_pin_o
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd1, A_CTL,  16'h0003, 8'h00, 16'h0000, 1'b1}, // R3 ien+oe
    '{2'd1, A_EVT,  16'h007F, 8'h00, 16'h0000, 1'b1}, // R7 enables
    '{2'd2, A_CTL,  16'h0000, 8'h00, 16'h0003, 1'b1}, // R3
    '{2'd0, A_STAT, 16'h0000, 8'h01, 16'h0000, 1'b0}, // R4 link slot 10, R10
    '{2'd2, A_EVT,  16'h0000, 8'h01, 16'h047F, 1'b1}, // R9
    '{2'd0, A_STAT, 16'h0000, 8'h03, 16'h0000, 1'b0}, // R4 speed slot 12
    '{2'd2, A_EVT,  16'h0000, 8'h03, 16'h107F, 1'b1}, // R4
    '{2'd0, A_STAT, 16'h0000, 8'h07, 16'h0000, 1'b0}, // R4 duplex slot 11
    '{2'd2, A_EVT,  16'h0000, 8'h07, 16'h087F, 1'b1}, // R4
    '{2'd2, A_STAT, 16'h0000, 8'h07, 16'h0007, 1'b1}, // R2
    '{2'd2, A_STAT, 16'h0000, 8'h07, 16'h0007, 1'b1}, // R2 link survives read
    '{2'd0, A_STAT, 16'h0000, 8'h27, 16'h0000, 1'b0}, // R4 counter slot 8
    '{2'd0, A_STAT, 16'h0000, 8'h57, 16'h0000, 1'b0}, // R4 an slot 9, lqm 14
    '{2'd2, A_EVT,  16'h0000, 8'h17, 16'h437F, 1'b1}, // R4
    '{2'd0, A_STAT, 16'h0000, 8'h1F, 16'h0000, 1'b0}, // R4 energy slot 13
    '{2'd2, A_EVT,  16'h0000, 8'h1F, 16'h207F, 1'b1}, // R4
    '{2'd0, A_STAT, 16'h0000, 8'h9F, 16'h0000, 1'b1}, // R6 ts ignored
    '{2'd2, A_EVT,  16'h0000, 8'h1F, 16'h007F, 1'b1}  // R6
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic link_up_i = 0, speed10_i = 0, full_dup_i = 0, energy_i = 0, an_done_i = 0;
  logic cnt_half_i = 0, lqm_evt_i = 0, ts_evt_i = 0, intr_pin_i = 1;
  logic intr_pin_o, intr_pin_oe, pwr_down_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_event_irq u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_up_i(link_up_i), .speed10_i(speed10_i), .full_dup_i(full_dup_i),
    .energy_i(energy_i), .an_done_i(an_done_i), .cnt_half_i(cnt_half_i),
    .lqm_evt_i(lqm_evt_i), .ts_evt_i(ts_evt_i), .intr_pin_i(intr_pin_i),
    .intr_pin_o(intr_pin_o), .intr_pin_oe(intr_pin_oe), .pwr_down_o(pwr_down_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, cross one rising edge, return at the next falling edge
  task automatic step(input logic [1:0] op, input logic [4:0] a,
                      input logic [15:0] wd, input logic [7:0] inp);
    reg_addr = a; reg_wdata = wd;
    reg_wr = (op == 2'd1); reg_rd = (op == 2'd2);
    link_up_i = inp[0]; speed10_i = inp[1]; full_dup_i = inp[2];
    energy_i = inp[3]; an_done_i = inp[4];
    cnt_half_i = inp[5]; lqm_evt_i = inp[6]; ts_evt_i = inp[7];
    @(posedge clk); @(negedge clk);
    reg_wr = 0; reg_rd = 0; cnt_half_i = 0; lqm_evt_i = 0; ts_evt_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 pin_oe", {15'd0, intr_pin_oe}, 16'd0);
    chk("R1 pin_o", {15'd0, intr_pin_o}, 16'd1);
    chk("R1 pwr_down", {15'd0, pwr_down_o}, 16'd0);
    step(2'd2, A_CTL, 16'h0, 8'h00);  chk("R1 ctl", reg_rdata, 16'h0000);
    step(2'd2, A_EVT, 16'h0, 8'h00);  chk("R1 evt", reg_rdata, 16'h0000);
    step(2'd2, A_STAT, 16'h0, 8'h00); chk("R1 stat", reg_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].inp);
      if (VEC[i].op == 2'd2) chk($sformatf("vec%0d rdata", i), reg_rdata, VEC[i].exp);
      chk($sformatf("vec%0d pin R10", i), {15'd0, intr_pin_o}, {15'd0, VEC[i].pin});
    end

    // R5: link down, then speed/duplex moves are ignored
    step(2'd0, A_STAT, 16'h0, 8'h1E); chk("R5 link drop pin", {15'd0, intr_pin_o}, 16'd0);
    step(2'd2, A_EVT, 16'h0, 8'h1E);  chk("R5 link drop evt", reg_rdata, 16'h047F);
    step(2'd0, A_STAT, 16'h0, 8'h1C); chk("R5 spd while down", {15'd0, intr_pin_o}, 16'd1);
    step(2'd0, A_STAT, 16'h0, 8'h18); chk("R5 dup while down", {15'd0, intr_pin_o}, 16'd1);
    step(2'd2, A_EVT, 16'h0, 8'h18);  chk("R5 no flags", reg_rdata, 16'h007F);

    // R6: remap select
    step(2'd1, A_CTL, 16'h000B, 8'h18);
    step(2'd0, A_STAT, 16'h0, 8'h98); chk("R6 ts pin", {15'd0, intr_pin_o}, 16'd0);
    step(2'd2, A_EVT, 16'h0, 8'h18);  chk("R6 ts slot11", reg_rdata, 16'h087F);
    step(2'd0, A_STAT, 16'h0, 8'h19);
    step(2'd2, A_EVT, 16'h0, 8'h19);  chk("R6 link up", reg_rdata, 16'h047F);
    step(2'd0, A_STAT, 16'h0, 8'h1D); chk("R6 dup pin", {15'd0, intr_pin_o}, 16'd0);
    step(2'd2, A_EVT, 16'h0, 8'h1D);  chk("R6 dup to slot12", reg_rdata, 16'h107F);

    // R7: gating by slot enable and global enable
    step(2'd1, A_EVT, 16'h0000, 8'h1D);
    step(2'd0, A_STAT, 16'h0, 8'h9D); chk("R7 slot disabled", {15'd0, intr_pin_o}, 16'd1);
    step(2'd2, A_EVT, 16'h0, 8'h1D);  chk("R7 flag latched", reg_rdata, 16'h0800);
    step(2'd1, A_EVT, 16'h007F, 8'h1D);
    step(2'd1, A_CTL, 16'h0009, 8'h1D);
    step(2'd0, A_STAT, 16'h0, 8'h9D); chk("R7 ien off", {15'd0, intr_pin_o}, 16'd1);
    step(2'd2, A_EVT, 16'h0, 8'h1D);  chk("R7 flag kept", reg_rdata, 16'h087F);

    // R8: test interrupt
    step(2'd1, A_CTL, 16'h0005, 8'h1D); chk("R8 forced", {15'd0, intr_pin_o}, 16'd0);
    for (int j = 0; j < 3; j++) begin
      step(2'd0, A_STAT, 16'h0, 8'h1D);
      chk("R8 held", {15'd0, intr_pin_o}, 16'd0);
    end
    step(2'd2, A_EVT, 16'h0, 8'h1D);  chk("R8 no flags", reg_rdata, 16'h007F);
    chk("R8 read no effect", {15'd0, intr_pin_o}, 16'd0);
    step(2'd1, A_CTL, 16'h0001, 8'h1D); chk("R8 released", {15'd0, intr_pin_o}, 16'd1);

    // R3: reserved bits ignore writes
    step(2'd1, A_CTL, 16'hFFF0, 8'h1D);
    step(2'd2, A_CTL, 16'h0, 8'h1D);  chk("R3 reserved", reg_rdata, 16'h0000);
    chk("R10 oe off", {15'd0, intr_pin_oe}, 16'd0);

    // R11: power-down input
    intr_pin_i = 0;
    step(2'd0, A_STAT, 16'h0, 8'h1D); chk("R11 pd req", {15'd0, pwr_down_o}, 16'd1);
    step(2'd1, A_CTL, 16'h0003, 8'h1D); chk("R10 oe on", {15'd0, intr_pin_oe}, 16'd1);
    step(2'd0, A_STAT, 16'h0, 8'h1D); chk("R11 pd masked", {15'd0, pwr_down_o}, 16'd0);
    intr_pin_i = 1;

    // R9: event in the same cycle as the clearing read
    step(2'd2, A_EVT, 16'h0, 8'h3D);  chk("R9 read before new", reg_rdata, 16'h007F);
    chk("R9 pin kept", {15'd0, intr_pin_o}, 16'd0);
    step(2'd2, A_EVT, 16'h0, 8'h1D);  chk("R9 flag kept", reg_rdata, 16'h017F);
    chk("R9 pin drops", {15'd0, intr_pin_o}, 16'd1);

    finish_run();
  end
endmodule